// File: doc/BRIEF.md
# Shared Bus Arbiter for an On-Chip and an Off-Chip Master

This block decides which of two masters owns one shared external bus. One master is on the chip. It uses a request, a grant and a transaction-done strobe. The other master is off the chip and uses a three-wire handshake: it raises a bus request, it receives a bus grant, and it drives a bus-busy line while its access runs. All pins here are active-high. Any pad inversion sits outside the block.

The arbiter runs in one of two modes. In equal mode, ownership alternates between the masters on a least-recently-used basis. In unequal mode, the configured master wins whenever both are asking. A granted or running transfer is never cut short.

For the off-chip master, the arbiter adds three timing rules:
- At least one full cycle passes between the request being sampled and the grant.
- After the grant, the off-chip master has a two-edge window to raise busy.
- After the grant is withdrawn, the on-chip master is held off until busy has been sampled low on three consecutive edges.

The address path, the data path and the transfer protocol are not part of this block.

Top module: `bus_share_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, both grants are low after that edge. The least-recently-used mark points at the off-chip master.
- R2: When no master owns the bus and both requests are seen at one edge in equal mode (`prio_sel` 00 or 11), the master used least recently gets the grant. Right after reset, that is the off-chip master.
- R3: In unequal mode, when both requests are seen at a decision point, `prio_sel` 01 gives the grant to the on-chip master and 10 gives it to the off-chip master.
- R4: The owner keeps its grant, with no gap, for as long as the other master is not requesting.
- R5: The on-chip owner keeps `int_req` high until its `int_done` pulse. It gives the bus up only at an edge where `int_done` is high or `int_req` is low.
- R6: `xm_gnt` never rises at the same edge at which `xm_req` is first sampled high. The earliest rise is one edge later.
- R7: `int_gnt` and `xm_gnt` are never high together.
- R8: After an off-chip grant, the grant is withdrawn only once `xm_busy` has been sampled low on two consecutive edges since the grant. This is the two-edge claim window. An edge with busy high always keeps the grant.
- R9: After `xm_gnt` falls, `int_gnt` rises only after `xm_busy` has been sampled low on three consecutive edges. A busy sample in that time restarts the count.
- R10: In equal mode, an owner that finishes while the other master is requesting hands the grant to the other master.
- R11: In unequal mode, a transfer that is running completes even while the higher-priority master waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock. All inputs are sampled on this edge. |
| rst_n | input | 1 | Synchronous active-low reset. |
| prio_sel | input | 2 | Priority setting: 00 or 11 equal, 01 on-chip higher, 10 off-chip higher. |
| int_req | input | 1 | Bus request from the on-chip master. |
| int_done | input | 1 | One-cycle strobe: the on-chip transfer ends. |
| int_gnt | output | 1 | Registered grant to the on-chip master. |
| xm_req | input | 1 | Bus request from the off-chip master. |
| xm_busy | input | 1 | Off-chip master is driving the bus. |
| xm_gnt | output | 1 | Registered grant to the off-chip master. |

## Verification
A wrong hand-over counter moves the grant edge by one cycle. Both the claim window and the hold-off after revocation end within three cycles, so such a fault shows at the grant outputs within three cycles. A least-recently-used mark that is stuck or inverted is visible only at the next tie or equal-mode hand-over, so that case is checked with fresh resets under each priority code. A missing request register shows up as an off-chip grant one edge early, on the very first request after idle.

// File: rtl/arb_pkg.sv
// Shared types for the bus-share arbiter.
// Assumes: single clock domain; owner encodings are internal only.
package arb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_INT  = 2'd1,
        OWN_EXT  = 2'd2,
        OWN_HOLD = 2'd3
    } own_t;

    localparam logic [1:0] PRI_INT_HI = 2'b01;
    localparam logic [1:0] PRI_EXT_HI = 2'b10;

endpackage

// File: rtl/arb_req_sample.sv
// Registers the off-chip request so that decisions use a value that is
// one edge old, giving at least one full cycle from request to grant.
// Assumes: the request is already synchronous to clk.
module arb_req_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    output logic req_q
);

    // Capture the off-chip request on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_in;
    end

endmodule

// File: rtl/arb_quiet_cnt.sv
// Counts consecutive edges with busy sampled low. The count saturates at
// MAX_RUN and is cleared whenever the owner state changes.
// Assumes: clr is high on the edge where the owner state changes.
module arb_quiet_cnt #(
    parameter int MAX_RUN = 3,
    parameter int CNT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             busy,
    output logic [CNT_W-1:0] run_len
);

    localparam logic [CNT_W-1:0] MAX_L = CNT_W'(MAX_RUN);

    logic [CNT_W-1:0] cnt_q;

    // Length of the quiet run including the current sample.
    always_comb begin
        if (busy)              run_len = '0;
        else if (cnt_q >= MAX_L) run_len = MAX_L;
        else                   run_len = cnt_q + 1'b1;
    end

    // Hold the run length; restart it on each change of owner.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= run_len;
    end

endmodule

// File: rtl/arb_pick.sv
// Chooses a winner when one or both masters want the bus, using the
// priority setting and the least-recently-used mark for ties.
// Assumes: codes other than the two unequal ones mean equal priority.
module arb_pick
    import arb_pkg::*;
(
    input  logic [1:0] prio_sel,
    input  logic       int_want,
    input  logic       ext_want,
    input  logic       lru_ext,
    output logic       give_any,
    output logic       give_ext
);

    // Resolve a single requester directly, and a tie by mode.
    always_comb begin
        give_any = int_want | ext_want;
        if (int_want && ext_want) begin
            case (prio_sel)
                PRI_INT_HI: give_ext = 1'b0;
                PRI_EXT_HI: give_ext = 1'b1;
                default:    give_ext = lru_ext;
            endcase
        end else begin
            give_ext = ext_want;
        end
    end

endmodule

// File: rtl/bus_share_arbiter.sv
// Top of the bus-share arbiter. Tracks the owner of the shared bus, opens
// the claim window after an off-chip grant, and enforces the hold-off
// before the on-chip master may use the bus again.
// Assumes: the on-chip master keeps int_req high until its int_done pulse;
// all inputs are synchronous to clk.
module bus_share_arbiter
    import arb_pkg::*;
#(
    parameter int WIN_CYC  = 2,
    parameter int HOLD_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] prio_sel,
    input  logic       int_req,
    input  logic       int_done,
    output logic       int_gnt,
    input  logic       xm_req,
    input  logic       xm_busy,
    output logic       xm_gnt
);

    localparam int MAX_RUN = (HOLD_CYC > WIN_CYC) ? HOLD_CYC : WIN_CYC;
    localparam int CNT_W   = $clog2(MAX_RUN + 1);
    localparam logic [CNT_W-1:0] WIN_L  = CNT_W'(WIN_CYC);
    localparam logic [CNT_W-1:0] HOLD_L = CNT_W'(HOLD_CYC);

    own_t             own_q, own_d;
    logic             lru_ext_q, lru_ext_d;
    logic             br_q;
    logic [CNT_W-1:0] run_len;
    logic             give_any, give_ext;
    logic             int_free;

    arb_req_sample u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (xm_req),
        .req_q  (br_q)
    );

    arb_quiet_cnt #(
        .MAX_RUN (MAX_RUN),
        .CNT_W   (CNT_W)
    ) u_quiet (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (own_d != own_q),
        .busy    (xm_busy),
        .run_len (run_len)
    );

    arb_pick u_pick (
        .prio_sel (prio_sel),
        .int_want (int_req),
        .ext_want (br_q),
        .lru_ext  (lru_ext_q),
        .give_any (give_any),
        .give_ext (give_ext)
    );

    // The on-chip owner is between transfers at this edge.
    assign int_free = int_done | ~int_req;

    // Next owner and least-recently-used mark.
    always_comb begin
        own_d     = own_q;
        lru_ext_d = lru_ext_q;
        case (own_q)
            OWN_NONE: if (give_any) own_d = give_ext ? OWN_EXT : OWN_INT;
            OWN_INT:  if (int_free && br_q && give_ext) own_d = OWN_EXT;
            OWN_EXT:  if (run_len >= WIN_L && int_req && !give_ext) own_d = OWN_HOLD;
            OWN_HOLD: if (run_len >= HOLD_L) own_d = int_req ? OWN_INT : OWN_NONE;
            default:  own_d = OWN_NONE;
        endcase
        if (own_d == OWN_INT && own_q != OWN_INT) lru_ext_d = 1'b1;
        if (own_d == OWN_EXT && own_q != OWN_EXT) lru_ext_d = 1'b0;
    end

    // Owner state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q     <= OWN_NONE;
            lru_ext_q <= 1'b1;
        end else begin
            own_q     <= own_d;
            lru_ext_q <= lru_ext_d;
        end
    end

    assign int_gnt = (own_q == OWN_INT);
    assign xm_gnt  = (own_q == OWN_EXT);

    // Reset clears both grants.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!int_gnt && !xm_gnt));

    // Idle owner keeps the grant when the other side is quiet.
    assert_park_int_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_gnt && !$past(xm_req)) |=> int_gnt);
    assert_park_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_gnt && !int_req) |=> xm_gnt);

    // On-chip transfer in progress is not interrupted.
    assert_int_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_gnt && int_req && !int_done) |=> int_gnt);

    // One full cycle from request sample to off-chip grant.
    assert_req_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xm_gnt) |-> $past(xm_req, 2));

    // Grants are exclusive.
    assert_grant_mutex_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_gnt && xm_gnt));

    // Busy off-chip master keeps its grant.
    assert_busy_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_gnt && xm_busy) |=> xm_gnt);

    // On-chip grant never follows an off-chip grant within three edges.
    assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_gnt) |-> (!$past(xm_gnt, 1) && !$past(xm_gnt, 2) && !$past(xm_gnt, 3)));

endmodule

// File: tb/tb_bus_share_arbiter.sv
`timescale 1ns/1ps
module tb_bus_share_arbiter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] prio_sel;
    logic       int_req, int_done, xm_req, xm_busy;
    logic       int_gnt, xm_gnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_f = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    bus_share_arbiter dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .prio_sel (prio_sel),
        .int_req  (int_req),
        .int_done (int_done),
        .int_gnt  (int_gnt),
        .xm_req   (xm_req),
        .xm_busy  (xm_busy),
        .xm_gnt   (xm_gnt)
    );

    // Reference model: 0 none, 1 on-chip, 2 off-chip, 3 hold-off.
    int m_st, m_q;
    bit m_lru_ext, m_brq;

    function automatic bit f_ext_wins(logic [1:0] p, bit iw, bit ew, bit lru);
        if (iw && ew) begin
            if (p == 2'b01) return 1'b0;
            if (p == 2'b10) return 1'b1;
            return lru;
        end
        return ew;
    endfunction

    always @(posedge clk) begin
        int nxt, run;
        bit ew;
        if (!rst_n) begin
            m_st = 0; m_q = 0; m_lru_ext = 1'b1; m_brq = 1'b0;
        end else begin
            run = xm_busy ? 0 : ((m_q >= 3) ? 3 : m_q + 1);
            ew  = f_ext_wins(prio_sel, int_req, m_brq, m_lru_ext);
            nxt = m_st;
            case (m_st)
                0: if (int_req || m_brq) nxt = ew ? 2 : 1;
                1: if ((int_done || !int_req) && m_brq && ew) nxt = 2;
                2: if (run >= 2 && int_req && !ew) nxt = 3;
                default: if (run >= 3) nxt = int_req ? 1 : 0;
            endcase
            if (nxt != m_st) begin
                m_q = 0;
                if (nxt == 1) m_lru_ext = 1'b1;
                if (nxt == 2) m_lru_ext = 1'b0;
            end else begin
                m_q = run;
            end
            m_st  = nxt;
            m_brq = xm_req;
        end
    end

    task automatic check(input string tag, input bit act_i, input bit act_x,
                         input bit exp_i, input bit exp_x);
        n_chk++;
        if (act_i !== exp_i || act_x !== exp_x) begin
            n_fail++;
            $display("FAIL %s: int_gnt/xm_gnt actual %0b/%0b expected %0b/%0b at %0t",
                     tag, act_i, act_x, exp_i, exp_x, $time);
        end
    endtask

    // Compare against the model at the negedge, then drive the next inputs.
    task automatic step(input bit ir, input bit id, input bit xr, input bit xb);
        @(negedge clk);
        check(phase, int_gnt, xm_gnt, m_st == 1, m_st == 2);
        int_req = ir; int_done = id; xm_req = xr; xm_busy = xb;
    endtask

    task automatic expect_out(input string tag, input bit ei, input bit ex);
        check(tag, int_gnt, xm_gnt, ei, ex);
    endtask

    task automatic do_reset(input logic [1:0] p);
        @(negedge clk);
        rst_n = 1'b0; prio_sel = p;
        int_req = 0; int_done = 0; xm_req = 0; xm_busy = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Tie from idle: off-chip request first, on-chip request one cycle later.
    task automatic tie_case(input logic [1:0] p, input string tag, input bit ext_exp);
        do_reset(p);
        phase = tag;
        step(0, 0, 1, 0);
        step(1, 0, 1, 0);
        step(1, 0, 1, 0);
        expect_out(tag, !ext_exp, ext_exp);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done_f) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(2'b00);
        @(negedge clk);
        expect_out("R1", 0, 0);
        rst_n = 1'b1;

        // R6: request latency, then R8 busy window and R9 hold-off.
        do_reset(2'b00);
        phase = "R6";
        step(0, 0, 1, 0);
        step(0, 0, 1, 0); expect_out("R6", 0, 0);
        step(1, 0, 1, 1); expect_out("R6", 0, 1);
        phase = "R8";
        step(1, 0, 1, 1); expect_out("R8", 0, 1);
        step(1, 0, 1, 1); expect_out("R8", 0, 1);
        step(1, 0, 1, 0); expect_out("R8", 0, 1);
        step(1, 0, 1, 0); expect_out("R8", 0, 1);
        phase = "R9";
        step(1, 0, 1, 0); expect_out("R8", 0, 0);
        step(1, 0, 1, 0); expect_out("R9", 0, 0);
        step(1, 0, 1, 0); expect_out("R9", 0, 0);
        step(1, 0, 1, 0); expect_out("R9", 1, 0);
        phase = "R5";
        step(1, 0, 1, 0); expect_out("R5", 1, 0);
        step(1, 1, 1, 0); expect_out("R5", 1, 0);
        phase = "R10";
        step(1, 0, 1, 0); expect_out("R10", 0, 1);
        step(1, 0, 1, 0); expect_out("R10", 0, 1);
        phase = "R9";
        step(1, 0, 1, 1); expect_out("R8", 0, 0);
        step(1, 0, 1, 0); expect_out("R9", 0, 0);
        step(1, 0, 1, 0); expect_out("R9", 0, 0);
        step(1, 0, 1, 0); expect_out("R9", 0, 0);
        step(1, 0, 1, 0); expect_out("R9", 1, 0);

        // R2 / R3: ties from idle under each priority code.
        tie_case(2'b00, "R2", 1'b1);
        tie_case(2'b11, "R2", 1'b1);
        tie_case(2'b01, "R3", 1'b0);
        tie_case(2'b10, "R3", 1'b1);

        // R3: on-chip higher keeps the bus across its own transfer ends.
        phase = "R3";
        do_reset(2'b01);
        step(1, 0, 1, 0);
        step(1, 0, 1, 0); expect_out("R3", 1, 0);
        step(1, 1, 1, 0);
        step(1, 0, 1, 0); expect_out("R3", 1, 0);

        // R11: off-chip higher waits for the running on-chip transfer.
        phase = "R11";
        do_reset(2'b10);
        step(1, 0, 0, 0);
        step(1, 0, 1, 0); expect_out("R11", 1, 0);
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 1, 0); expect_out("R11", 1, 0);
        end
        step(1, 1, 1, 0);
        step(1, 0, 1, 0); expect_out("R11", 0, 1);

        // R4: owners park while the other master is quiet.
        phase = "R4";
        do_reset(2'b00);
        step(1, 0, 0, 0);
        for (int i = 0; i < 5; i++) begin
            step((i % 2) == 0, i == 2, 0, 0);
            if (i > 0) expect_out("R4", 1, 0);
        end

        // Random traffic checked cycle by cycle against the model (R7, R10).
        phase = "R7";
        do_reset(2'b00);
        for (int i = 0; i < 6000; i++) begin
            bit ir, id, xr, xb;
            if ((i % 300) == 0) prio_sel = 2'($urandom_range(0, 3));
            ir = ($urandom_range(0, 9) < 6);
            id = int_gnt && ($urandom_range(0, 3) == 0);
            xr = ($urandom_range(0, 9) < 5);
            xb = xm_gnt ? ($urandom_range(0, 2) != 0) : ($urandom_range(0, 19) == 0);
            step(ir, id, xr, xb);
            if (int_gnt && xm_gnt) check("R7", int_gnt, xm_gnt, int_gnt, 1'b0);
        end

        done_f = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule